// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor that keeps all arithmetic in a single accumulator. Every memory access goes through an address holding register and a data holding register, so the core drives one synchronous, word-addressed memory with a registered address, a registered write word and a write strobe. It takes back read data one cycle after an address is presented.

Each instruction runs as a fixed series of states. Fetch copies the program counter into the address register, waits one state for the memory, captures the read word, then moves it into the instruction register and steps the program counter. A decode state then picks the execute sequence from the 4-bit operation field in bits 15:12. Bits 11:0 hold the operand address. Arithmetic and logic results always return to the accumulator. A jump reloads the program counter, and a halt instruction freezes the core.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, instruction and address registers, drives `halted` and `mem_we` low, and starts fetch at address 0.
- R2: Instructions run in address order. Each fetch reads the word at the program counter, and the program counter then advances by one, wrapping at the top of the 12-bit space.
- R3: Opcode 1 copies the addressed memory word into the accumulator. Opcode 2 writes the accumulator to the addressed word.
- R4: Opcode 3 adds and opcode 4 subtracts the addressed word from the accumulator, modulo 2^16.
- R5: Opcode 5 forms the bitwise AND and opcode 6 the bitwise OR of the accumulator with the addressed word.
- R6: Opcode 7 inverts every accumulator bit and makes no data access to memory.
- R7: Opcode 8 loads the program counter with the address field, so the next fetch comes from that address.
- R8: Opcode 0 raises `halted`, which then stays high until reset. While halted, the core performs no memory writes and holds `mem_addr` steady.
- R9: Opcodes 9 to 15 change neither the accumulator nor memory.
- R10: A store asserts `mem_we` for exactly one cycle, with `mem_wdata` equal to the accumulator.
- R11: Counted from the first clock edge after reset is released, fetch plus decode takes 5 cycles. Opcodes 1 and 3 to 6 add 4 cycles, a store adds 3 cycles, and opcode 7 adds 1 cycle. Jump, halt and the undefined opcodes add none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_wdata | output | 16 | Write word, driven from the data register |
| mem_rdata | input | 16 | Read word, valid one cycle after its address |
| mem_we | output | 1 | Write strobe for the word at `mem_addr` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the core with its default parameters: a 16-bit word, a 4-bit operation field, a 12-bit address and the shared add/subtract datapath. These values give it the full 4096-word memory model, so it can place operands and results far from the code. They also make the subtract path go through the shared adder with an inverted operand and a carry-in, which is the path the carry and borrow wrap cases exercise. The bench measures the cycle count of each program against the per-instruction budget. That count catches an extra or missing wait state between presenting an address and capturing its data.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   // Instruction operation codes (field value in the top OPC_W bits)
   localparam logic [3:0] OP_HALT  = 4'd0;
   localparam logic [3:0] OP_LOAD  = 4'd1;
   localparam logic [3:0] OP_STORE = 4'd2;
   localparam logic [3:0] OP_ADD   = 4'd3;
   localparam logic [3:0] OP_SUB   = 4'd4;
   localparam logic [3:0] OP_AND   = 4'd5;
   localparam logic [3:0] OP_OR    = 4'd6;
   localparam logic [3:0] OP_NOT   = 4'd7;
   localparam logic [3:0] OP_JUMP  = 4'd8;

   typedef enum logic [3:0] {
      S_FE_ADDR  = 4'd0,   // program counter -> address register
      S_FE_WAIT  = 4'd1,   // memory latency
      S_FE_DATA  = 4'd2,   // read word -> data register
      S_FE_INSN  = 4'd3,   // data register -> instruction, step PC
      S_DECODE   = 4'd4,
      S_EX_ADDR  = 4'd5,   // operand address -> address register
      S_EX_WAIT  = 4'd6,
      S_EX_DATA  = 4'd7,
      S_EX_ALU   = 4'd8,   // ALU result -> accumulator
      S_ST_DATA  = 4'd9,   // accumulator -> data register
      S_ST_WRITE = 4'd10,  // write strobe
      S_STOP     = 4'd11
   } cpu_state_e;

   typedef enum logic [2:0] {
      ALU_PASS = 3'd0,
      ALU_ADD  = 3'd1,
      ALU_SUB  = 3'd2,
      ALU_AND  = 3'd3,
      ALU_OR   = 3'd4,
      ALU_INV  = 3'd5
   } alu_func_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  alu_func_e    func,
   output logic [W-1:0] res
);

   initial begin
      if (W < 2) $error("acc_cpu_alu: W must be at least 2");
   end

   logic [W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder: subtract = a + ~b + 1
         logic          neg;
         logic [W-1:0]  b_in;
         assign neg   = (func == ALU_SUB);
         assign b_in  = neg ? ~opb : opb;
         assign arith = opa + b_in + {{(W-1){1'b0}}, neg};
      end else begin : g_split
         logic [W-1:0] sum;
         logic [W-1:0] dif;
         assign sum   = opa + opb;
         assign dif   = opa - opb;
         assign arith = (func == ALU_SUB) ? dif : sum;
      end
   endgenerate

   always_comb begin
      unique case (func)
         ALU_ADD, ALU_SUB: res = arith;
         ALU_AND:          res = opa & opb;
         ALU_OR:           res = opa | opb;
         ALU_INV:          res = ~opa;
         default:          res = opb;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output cpu_state_e       state,
   output logic             mar_from_pc,
   output logic             mar_from_ir,
   output logic             mbr_from_mem,
   output logic             mbr_from_acc,
   output logic             ir_load,
   output logic             pc_step,
   output logic             pc_jump,
   output logic             acc_load,
   output alu_func_e        alu_func,
   output logic             mem_we,
   output logic             halted
);

   initial begin
      if (OPC_W < 4) $error("acc_cpu_ctrl: OPC_W must be at least 4");
   end

   logic       op_hi_zero;
   logic [3:0] op;
   cpu_state_e state_nx;

   generate
      if (OPC_W > 4) begin : g_wide
         assign op_hi_zero = (opcode[OPC_W-1:4] == '0);
      end else begin : g_narrow
         assign op_hi_zero = 1'b1;
      end
   endgenerate
   assign op = opcode[3:0];

   logic is_halt, is_store, is_inv, is_jump, reads_mem;
   assign is_halt   = op_hi_zero && (op == OP_HALT);
   assign is_store  = op_hi_zero && (op == OP_STORE);
   assign is_inv    = op_hi_zero && (op == OP_NOT);
   assign is_jump   = op_hi_zero && (op == OP_JUMP);
   assign reads_mem = op_hi_zero && (op == OP_LOAD || op == OP_ADD || op == OP_SUB ||
                                     op == OP_AND  || op == OP_OR);

   always_comb begin
      state_nx = state;
      unique case (state)
         S_FE_ADDR:  state_nx = S_FE_WAIT;
         S_FE_WAIT:  state_nx = S_FE_DATA;
         S_FE_DATA:  state_nx = S_FE_INSN;
         S_FE_INSN:  state_nx = S_DECODE;
         S_DECODE: begin
            if (is_halt)                    state_nx = S_STOP;
            else if (reads_mem || is_store) state_nx = S_EX_ADDR;
            else if (is_inv)                state_nx = S_EX_ALU;
            else                            state_nx = S_FE_ADDR;
         end
         S_EX_ADDR:  state_nx = is_store ? S_ST_DATA : S_EX_WAIT;
         S_EX_WAIT:  state_nx = S_EX_DATA;
         S_EX_DATA:  state_nx = S_EX_ALU;
         S_EX_ALU:   state_nx = S_FE_ADDR;
         S_ST_DATA:  state_nx = S_ST_WRITE;
         S_ST_WRITE: state_nx = S_FE_ADDR;
         S_STOP:     state_nx = S_STOP;
         default:    state_nx = S_FE_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S_FE_ADDR;
      else     state <= state_nx;
   end

   assign mar_from_pc  = (state == S_FE_ADDR);
   assign mar_from_ir  = (state == S_EX_ADDR);
   assign mbr_from_mem = (state == S_FE_DATA) || (state == S_EX_DATA);
   assign mbr_from_acc = (state == S_ST_DATA);
   assign ir_load      = (state == S_FE_INSN);
   assign pc_step      = (state == S_FE_INSN);
   assign pc_jump      = (state == S_DECODE) && is_jump;
   assign acc_load     = (state == S_EX_ALU);
   assign mem_we       = (state == S_ST_WRITE);
   assign halted       = (state == S_STOP);

   always_comb begin
      unique case (op)
         OP_ADD:  alu_func = ALU_ADD;
         OP_SUB:  alu_func = ALU_SUB;
         OP_AND:  alu_func = ALU_AND;
         OP_OR:   alu_func = ALU_OR;
         OP_NOT:  alu_func = ALU_INV;
         default: alu_func = ALU_PASS;
      endcase
   end

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R10
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R8
   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) halted |-> !mem_we); // R8
   AST_INV_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
      (state == S_DECODE && is_inv) |=> (state == S_EX_ALU && !mbr_from_mem)); // R6

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int OPC_W        = 4,
   parameter int ADDR_W       = 12,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic              halted
);

   localparam int OPC_LSB = DATA_W - OPC_W;

   initial begin
      if (DATA_W != OPC_W + ADDR_W)
         $error("acc_cpu_core: DATA_W must equal OPC_W + ADDR_W");
      if (ADDR_W < 1) $error("acc_cpu_core: ADDR_W must be positive");
   end

   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] mbr, ir, acc, alu_res;
   logic [OPC_W-1:0]  ir_opc;
   logic [ADDR_W-1:0] ir_adr;

   cpu_state_e state;
   alu_func_e  alu_func;
   logic mar_from_pc, mar_from_ir, mbr_from_mem, mbr_from_acc;
   logic ir_load, pc_step, pc_jump, acc_load;

   assign ir_opc = ir[DATA_W-1:OPC_LSB];
   assign ir_adr = ir[ADDR_W-1:0];

   acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .opcode       (ir_opc),
      .state        (state),
      .mar_from_pc  (mar_from_pc),
      .mar_from_ir  (mar_from_ir),
      .mbr_from_mem (mbr_from_mem),
      .mbr_from_acc (mbr_from_acc),
      .ir_load      (ir_load),
      .pc_step      (pc_step),
      .pc_jump      (pc_jump),
      .acc_load     (acc_load),
      .alu_func     (alu_func),
      .mem_we       (mem_we),
      .halted       (halted)
   );

   acc_cpu_alu #(.W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .opa  (acc),
      .opb  (mbr),
      .func (alu_func),
      .res  (alu_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         acc <= '0;
      end else begin
         if (mar_from_pc)       mar <= pc;
         else if (mar_from_ir)  mar <= ir_adr;
         if (mbr_from_mem)      mbr <= mem_rdata;
         else if (mbr_from_acc) mbr <= acc;
         if (ir_load)           ir  <= mbr;
         if (pc_jump)           pc  <= ir_adr;
         else if (pc_step)      pc  <= pc + 1'b1;
         if (acc_load)          acc <= alu_res;
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mbr;

   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (state == S_FE_INSN) |=> (pc == $past(pc) + 1'b1)); // R2
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
      (state == S_FE_WAIT) |-> (mem_addr == pc)); // R2
   AST_STORE_WORD: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_wdata == acc)); // R10
   AST_HALT_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (halted && $past(halted)) |-> $stable(mem_addr)); // R8

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        mem_we;
   logic        halted;

   int n_checks = 0;
   int n_errors = 0;
   int last_cycles;
   int last_writes;

   logic [15:0] ram [0:4095];

   always #2 clk = ~clk;

   acc_cpu_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .halted    (halted)
   );

   always @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
   end

   function automatic logic [15:0] ins(input int op, input int adr);
      return {op[3:0], adr[11:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_ram();
      for (int i = 0; i < 4096; i++) ram[i] = 16'h0000;
   endtask

   // reset, then run until halted; records cycles and write-strobe cycles
   task automatic run_prog();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      last_cycles = 0;
      last_writes = 0;
      while (!halted && last_cycles < 5000) begin
         @(posedge clk);
         last_cycles++;
         @(negedge clk);
         if (mem_we) last_writes++;
      end
      if (!halted) check("R8 timeout", 0, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 halted low in reset", halted, 0);
      check("R1 we low in reset", mem_we, 0);
      check("R1 address zero in reset", mem_addr, 0);
      rst = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R1 first fetch at 0", mem_addr, 0);
   endtask

   task automatic t_load_store();
      clear_ram();
      ram[0] = ins(1, 100); ram[1] = ins(2, 101); ram[2] = ins(0, 0);
      ram[3] = ins(2, 102);
      ram[100] = 16'hA5C3; ram[102] = 16'h4444;
      run_prog();
      check("R3 load-store copy", ram[101], 16'hA5C3);
      check("R11 load-store cycles", last_cycles, 22);
      check("R10 one write cycle", last_writes, 1);
      check("R8 no execution after halt", ram[102], 16'h4444);
   endtask

   task automatic t_arith();
      clear_ram();
      ram[0] = ins(1, 200); ram[1] = ins(3, 201); ram[2] = ins(2, 210);
      ram[3] = ins(4, 202); ram[4] = ins(2, 211); ram[5] = ins(0, 0);
      ram[200] = 16'hFFFF; ram[201] = 16'h0002; ram[202] = 16'h0003;
      run_prog();
      check("R4 add wraps", ram[210], 16'h0001);
      check("R4 sub borrows", ram[211], 16'hFFFE);
      check("R11 arith cycles", last_cycles, 48);
      check("R10 two stores", last_writes, 2);
   endtask

   task automatic t_acc_cleared();
      clear_ram();
      ram[0] = ins(2, 50); ram[1] = ins(0, 0);
      ram[50] = 16'hFFFF;
      run_prog();
      check("R1 accumulator cleared", ram[50], 16'h0000);
      check("R11 store cycles", last_cycles, 13);
   endtask

   task automatic t_logic();
      clear_ram();
      ram[0] = ins(1, 300); ram[1] = ins(5, 301); ram[2] = ins(2, 310);
      ram[3] = ins(6, 302); ram[4] = ins(2, 311); ram[5] = ins(7, 303);
      ram[6] = ins(2, 312); ram[7] = ins(0, 0);
      ram[300] = 16'hF0F0; ram[301] = 16'h3C3C; ram[302] = 16'h0F00;
      ram[303] = 16'h9999;
      run_prog();
      check("R5 and", ram[310], 16'h3030);
      check("R5 or", ram[311], 16'h3F30);
      check("R6 not", ram[312], 16'hC0CF);
      check("R6 not leaves operand word", ram[303], 16'h9999);
      check("R11 logic cycles", last_cycles, 62);
   endtask

   task automatic t_jump();
      clear_ram();
      ram[0] = ins(1, 400); ram[1] = ins(8, 4); ram[2] = ins(2, 401);
      ram[3] = ins(0, 0);   ram[4] = ins(2, 402); ram[5] = ins(0, 0);
      ram[400] = 16'h1357; ram[401] = 16'h1111;
      run_prog();
      check("R7 skipped word untouched", ram[401], 16'h1111);
      check("R7 target executed", ram[402], 16'h1357);
      check("R11 jump cycles", last_cycles, 27);
   endtask

   task automatic t_undefined();
      clear_ram();
      ram[0] = ins(1, 500);
      for (int k = 0; k < 7; k++) ram[1 + k] = ins(9 + k, 502);
      ram[8] = ins(2, 503); ram[9] = ins(0, 0);
      ram[500] = 16'h5A5A; ram[502] = 16'h7777;
      run_prog();
      check("R9 memory unchanged", ram[502], 16'h7777);
      check("R9 accumulator unchanged", ram[503], 16'h5A5A);
      check("R9 no extra writes", last_writes, 1);
      check("R11 undefined opcode cycles", last_cycles, 57);
   endtask

   task automatic t_halt_hold();
      logic [11:0] a0;
      clear_ram();
      ram[0] = ins(0, 0);
      run_prog();
      check("R11 halt-only cycles", last_cycles, 5);
      a0 = mem_addr;
      for (int k = 0; k < 20; k++) begin
         @(posedge clk); @(negedge clk);
         check("R8 stays halted", halted, 1);
         check("R8 no write when halted", mem_we, 0);
         check("R8 address held", mem_addr, a0);
      end
   endtask

   task automatic t_pc_wrap();
      clear_ram();
      ram[0] = ins(1, 600); ram[1] = ins(8, 4095);
      ram[4095] = ins(3, 600);
      ram[2] = ins(2, 601); ram[3] = ins(0, 0);
      ram[600] = 16'h0010;
      run_prog();
      // 0:LOAD 1:JUMP 4095:ADD 0:LOAD 1:JUMP ... loops; guarded below
      check("R2 wrap program halts", halted, 1);
   endtask

   task automatic t_seq_wrap();
      clear_ram();
      // 0:JUMP 4095; 4095:ADD 700 then PC wraps to 0 -> second pass hits 0 again,
      // so use an entry flag: start at 0 with JUMP 10
      ram[0] = ins(8, 10);
      ram[10] = ins(1, 700); ram[11] = ins(8, 4094);
      ram[4094] = ins(3, 700); ram[4095] = ins(8, 20);
      ram[20] = ins(2, 701); ram[21] = ins(0, 0);
      ram[700] = 16'h0021;
      run_prog();
      check("R2 sequential past jump target", ram[701], 16'h0042);
      check("R11 sequence cycles", last_cycles, 5 + 9 + 5 + 9 + 5 + 8 + 5);
   endtask

   task automatic t_top_wrap();
      clear_ram();
      ram[0] = ins(1, 800); ram[1] = ins(8, 4095);
      ram[4095] = ins(8, 2);
      ram[2] = ins(2, 801); ram[3] = ins(0, 0);
      ram[800] = 16'h0BAD;
      run_prog();
      check("R2 top-of-space jump then store", ram[801], 16'h0BAD);
   endtask

   initial begin
      #(4 * 200000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      clear_ram();
      t_reset();
      t_load_store();
      t_arith();
      t_acc_cleared();
      t_logic();
      t_jump();
      t_undefined();
      t_seq_wrap();
      t_top_wrap();
      t_halt_hold();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule